// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit

This unit adds or subtracts two 40-bit floating-point words. Each word has a sign bit in bit 39, an 8-bit exponent in bits 38:31 and a 31-bit fraction in bits 30:0. The format has no hidden bit: a normalised value keeps a 1 in fraction bit 30, and the word is not IEEE compatible. The value is proportional to (-1)^sign * fraction * 2^exponent, so no exponent bias takes part in the arithmetic.

A caller places both operands and the operation select on the inputs, then raises `start` for one cycle. In that cycle the unit finds the operand with the larger magnitude, aligns the other operand with a single-pass right barrel shift, adds or subtracts the fractions, counts leading zeros and normalises with a single-pass left barrel shift. The result is registered, and `done` pulses in the following cycle. Shifted-out bits are truncated and no rounding is applied.

Top module: `fpas_unit`

## Requirements
- R1: `done` is high exactly in the cycle after each cycle in which `start` is high. `result` changes only on the clock edge that follows a `start` cycle and holds its value otherwise.
- R2: When both operands have the same effective sign, the fraction of the operand with the smaller magnitude is shifted right by the exponent difference, with truncation, and added to the larger fraction. The result takes the larger exponent.
- R3: When the exponent difference is greater than 31, the smaller operand contributes nothing. For a normalised larger operand, the result equals that operand with its effective sign.
- R4: When `op_sub` is 1, the sign of operand B is inverted before the operation. When the effective signs differ, the aligned smaller fraction is subtracted from the larger one by inverting the adder input and adding 1.
- R5: When the fraction sum carries out of bit 30, the fraction is shifted right by one, dropping the lowest bit, and the exponent rises by one.
- R6: A nonzero, non-carry sum is shifted left by its count of leading zeros, so that bit 30 of the fraction is 1. The exponent is reduced by the same count.
- R7: A zero sum gives an all-zero result word, sign bit included.
- R8: When the normalising shift is larger than the larger exponent (exponent underflow), the result is the all-zero word.
- R9: When a carry occurs while the larger exponent is 255, the result exponent saturates at 255 and the shifted fraction is kept.
- R10: The result sign is the effective sign of the operand whose {exponent, fraction} magnitude is larger. On a tie, operand A's sign is used.
- R11: After reset, `result` is zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operands valid; begin an operation |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| opa | input | 40 | Operand A: sign[39], exponent[38:31], fraction[30:0] |
| opb | input | 40 | Operand B, same layout |
| result | output | 40 | Registered result word |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The assertions and the reference model assume that every operand is either normalised (fraction bit 30 set) or the all-zero word. When operands are not normalised, the subtraction can borrow past the larger fraction, and the far-shift and carry rules no longer describe a meaningful result. The random stimulus therefore builds each fraction with bit 30 forced high, or else emits a zero word. It draws exponents close together often enough to exercise the alignment, cancellation and underflow paths. Directed cases cover the saturating exponent and the tie in magnitude.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 31;

  typedef enum logic {
    FPAS_ADD = 1'b0,
    FPAS_SUB = 1'b1
  } fpas_op_e;
endpackage

// File: rtl/fpas_shift.sv
// Logarithmic barrel shifter, direction chosen by parameter.
module fpas_shift #(
  parameter int W    = 31,
  parameter int SW   = 5,
  parameter bit LEFT = 1'b0
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [SW+1];
  assign stage[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    if (LEFT) begin : g_l
      assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
    end else begin : g_r
      assign stage[i+1] = amt[i] ? (stage[i] >> (1 << i)) : stage[i];
    end
  end

  assign dout = stage[SW];
endmodule

// File: rtl/fpas_lzc.sv
// Leading zero counter; an all-zero input reports W.
module fpas_lzc #(
  parameter int W  = 31,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    cnt   = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && din[i]) begin
        cnt   = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpas_unit.sv
module fpas_unit
  import fpas_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          op_sub,
  input  logic [EXP_W+FRAC_W:0]         opa,
  input  logic [EXP_W+FRAC_W:0]         opb,
  output logic [EXP_W+FRAC_W:0]         result,
  output logic                          done
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam int SW    = $clog2(FRAC_W + 1);

  // operand ordering by magnitude
  logic             sgn_a, sgn_b, a_big, big_s, eff_sub;
  logic [EXP_W-1:0] big_e, sm_e, exp_diff;
  logic [FRAC_W-1:0] big_f, sm_f, sm_sh, sm_al;

  assign sgn_a   = opa[W-1];
  assign sgn_b   = opb[W-1] ^ (fpas_op_e'(op_sub) == FPAS_SUB);
  assign a_big   = opa[MAG_W-1:0] >= opb[MAG_W-1:0];
  assign big_s   = a_big ? sgn_a : sgn_b;
  assign big_e   = a_big ? opa[MAG_W-1:FRAC_W] : opb[MAG_W-1:FRAC_W];
  assign sm_e    = a_big ? opb[MAG_W-1:FRAC_W] : opa[MAG_W-1:FRAC_W];
  assign big_f   = a_big ? opa[FRAC_W-1:0] : opb[FRAC_W-1:0];
  assign sm_f    = a_big ? opb[FRAC_W-1:0] : opa[FRAC_W-1:0];
  assign eff_sub = sgn_a ^ sgn_b;
  assign exp_diff = big_e - sm_e;

  // named events for the assertions
  logic ev_far, ev_carry, ev_zero, ev_under, ev_over;
  assign ev_far = exp_diff > EXP_W'(FRAC_W);

  fpas_shift #(.W(FRAC_W), .SW(SW), .LEFT(1'b0)) u_align (
    .din (sm_f),
    .amt (exp_diff[SW-1:0]),
    .dout(sm_sh)
  );
  assign sm_al = ev_far ? '0 : sm_sh;

  // add or subtract via conditional inversion
  logic [FRAC_W:0] add_in, raw;
  assign add_in = {1'b0, sm_al} ^ {(FRAC_W+1){eff_sub}};
  assign raw    = {1'b0, big_f} + add_in + {{FRAC_W{1'b0}}, eff_sub};

  logic [SW-1:0]     lz;
  logic [FRAC_W-1:0] norm_f;

  fpas_lzc #(.W(FRAC_W), .CW(SW)) u_lzc (
    .din(raw[FRAC_W-1:0]),
    .cnt(lz)
  );

  fpas_shift #(.W(FRAC_W), .SW(SW), .LEFT(1'b1)) u_norm (
    .din (raw[FRAC_W-1:0]),
    .amt (lz),
    .dout(norm_f)
  );

  assign ev_carry = raw[FRAC_W];
  assign ev_zero  = (raw == '0);
  assign ev_under = !ev_carry && !ev_zero && (EXP_W'(lz) > big_e);
  assign ev_over  = ev_carry && (big_e == '1);

  logic [W-1:0] res_next;
  always_comb begin
    if (ev_carry) begin
      res_next = {big_s, ev_over ? big_e : big_e + EXP_W'(1), raw[FRAC_W:1]};
    end else if (ev_zero || ev_under) begin
      res_next = '0;
    end else begin
      res_next = {big_s, big_e - EXP_W'(lz), norm_f};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) result <= res_next;
    end
  end

  // ---------------- assertions ----------------
  assert_done_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_result_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  assert_far_passes_big_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start && ev_far && big_f[FRAC_W-1] |=> result == $past({big_s, big_e, big_f}));
  assert_carry_bumps_exp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start && ev_carry && !ev_over |=> result[W-2:FRAC_W] == $past(big_e) + EXP_W'(1));
  assert_normalised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result[FRAC_W-1:0] != '0) |-> result[FRAC_W-1]);
  assert_zero_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result[FRAC_W-1:0] == '0) |-> result == '0);
  assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && ev_under |=> result == '0);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && ev_over |=> result[W-2:FRAC_W] == '1);
  assert_sign_of_big_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !ev_zero && !ev_under |=> result[W-1] == $past(big_s));
endmodule

// File: tb/fpas_unit_tb.sv
module fpas_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_sub = 1'b0;
  logic [39:0] opa = '0;
  logic [39:0] opb = '0;
  logic [39:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;

  fpas_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .opa(opa), .opb(opb), .result(result), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [39:0] mk(input logic s, input int e, input logic [30:0] f);
    return {s, 8'(e), f};
  endfunction

  // Reference model written from the requirements with integer arithmetic.
  function automatic logic [39:0] ref_model(input logic [39:0] a, input logic [39:0] b,
                                            input logic sub);
    logic  sa, sb, sbig;
    longint ea, eb, fa, fb, ebig, fbig, fsm, d, r;
    sa = a[39]; sb = b[39] ^ sub;
    ea = longint'(a[38:31]); eb = longint'(b[38:31]);
    fa = longint'(a[30:0]);  fb = longint'(b[30:0]);
    if ((ea > eb) || (ea == eb && fa >= fb)) begin
      sbig = sa; ebig = ea; fbig = fa; d = ea - eb; fsm = fb;
    end else begin
      sbig = sb; ebig = eb; fbig = fb; d = eb - ea; fsm = fa;
    end
    fsm = (d > 31) ? 0 : (fsm >> d);
    r = (sa == sb) ? fbig + fsm : fbig - fsm;
    if (r >= (64'd1 << 31)) begin
      r = r >> 1;
      ebig = (ebig == 255) ? 255 : ebig + 1;
    end else if (r == 0) begin
      return '0;
    end else begin
      while (r < (64'd1 << 30)) begin
        r = r << 1;
        ebig = ebig - 1;
      end
      if (ebig < 0) return '0;
    end
    return {sbig, 8'(ebig), 31'(r)};
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [39:0] a, input logic [39:0] b, input logic sub,
                     input string tag);
    @(negedge clk);
    opa = a; opb = b; op_sub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " done"}, {39'd0, done}, 40'd1);
    check(tag, result, ref_model(a, b, sub));
  endtask

  function automatic logic [39:0] rnd_op(input int base_e);
    int e;
    if ($urandom_range(0, 9) == 0) return '0;
    e = (base_e < 0) ? int'($urandom_range(0, 255))
                     : base_e + int'($urandom_range(0, 6)) - 3;
    if (e < 0) e = 0;
    if (e > 255) e = 255;
    return {1'($urandom), 8'(e), 1'b1, 30'($urandom)};
  endfunction

  initial begin
    int seed;
    seed = $urandom(1234);
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 result", result, '0);
    check("R11 done", {39'd0, done}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: equal operands carry out
    run(mk(0, 100, 31'h40000000), mk(0, 100, 31'h40000000), 1'b0, "R5 carry");
    check("R5 value", result, mk(0, 101, 31'h40000000));
    // R2: one-step alignment
    run(mk(0, 100, 31'h40000000), mk(0, 99, 31'h40000000), 1'b0, "R2 align");
    check("R2 value", result, mk(0, 100, 31'h60000000));
    // R1: result held and done low without start
    held = result;
    @(negedge clk);
    check("R1 hold", result, held);
    check("R1 done low", {39'd0, done}, 40'd0);
    // R7: a - a is the zero word
    run(mk(1, 77, 31'h5A5A5A5A), mk(1, 77, 31'h5A5A5A5A), 1'b1, "R7 zero");
    check("R7 value", result, '0);
    // R3: far apart, add and subtract
    run(mk(1, 200, 31'h4ABCDEF1), mk(0, 100, 31'h7FFFFFFF), 1'b0, "R3 far add");
    check("R3 value", result, mk(1, 200, 31'h4ABCDEF1));
    run(mk(0, 10, 31'h40000000), mk(0, 60, 31'h41234567), 1'b1, "R3 far sub");
    check("R3 sub value", result, mk(1, 60, 31'h41234567));
    // R10: larger negative operand sets sign
    run(mk(0, 50, 31'h40000000), mk(1, 60, 31'h40000000), 1'b0, "R10 sign");
    check("R10 value", result, mk(1, 59, 31'h7FE00000));
    // R4: subtracting a negative doubles
    run(mk(0, 30, 31'h40000000), mk(1, 30, 31'h40000000), 1'b1, "R4 sub neg");
    check("R4 value", result, mk(0, 31, 31'h40000000));
    // R8: cancellation below zero exponent
    run(mk(0, 2, 31'h40000001), mk(0, 2, 31'h40000000), 1'b1, "R8 underflow");
    check("R8 value", result, '0);
    // R6: deep normalisation
    run(mk(0, 40, 31'h40000001), mk(0, 40, 31'h40000000), 1'b1, "R6 normalise");
    check("R6 value", result, mk(0, 10, 31'h40000000));
    // R9: saturating exponent
    run(mk(0, 255, 31'h60000000), mk(0, 255, 31'h60000000), 1'b0, "R9 overflow");
    check("R9 value", result, mk(0, 255, 31'h60000000));
    // R2: zero operand
    run('0, mk(1, 9, 31'h55555555), 1'b0, "R2 zero operand");

    // random mix, R2 R4 R6 R10
    for (int i = 0; i < 400; i++) begin
      int be;
      be = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 255));
      run(rnd_op(be), rnd_op(be), 1'($urandom), "R2 R4 R6 R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule